// File: doc/BRIEF.md
# Multi-Context Generator State Readout Window

This block gives software a narrow view into the stored state of a random bit generator that serves several application contexts. There are `HW_CTX` hardware contexts plus one software context. The software context always has the highest index, `HW_CTX`. The per-context state arrives on flat input buses: a reseed counter, a V block, a key, a compliance flag and an instantiated flag. The block does not hold that state itself.

Software first writes a context index through a plain select strobe. It then pulls words one at a time over a valid/ready read channel. Each accepted read moves an internal word pointer forward.

The requester raises `rd_valid_i`. A word counts as accepted in any cycle where `rd_valid_i` and `rd_ready_o` are both high. On that cycle `rd_data_o` carries the word and the pointer advances at the clock edge. `rd_ready_o` is low only in a cycle that carries a select write. That is the only back-pressure the block applies, and a requester that sees ready low must hold its request.

Readout is allowed only when two redundant multi-bit enables are both in their true encoding. In every other case each word reads as zero.

Top module: `state_readout_window`

## Requirements
- R1: A select write with `sel_idx_i` below `HW_CTX+1` streams that context's state. Index `HW_CTX` is the software context.
- R2: In a cycle with `sel_we_i` high, `rd_ready_o` is low. In the cycle right after the write, the first word of the new context is on `rd_data_o`.
- R3: Accepted reads return the words in this order: reseed counter words, then V words, then key words, then one status word. With the default widths that is word 0 for the counter, words 1 to 4 for V, words 5 to 12 for the key and word 13 for status.
- R4: Within each multi-word field, the least significant 32-bit word comes out first.
- R5: In the status word, bit 1 is the compliance flag, bit 0 is the instantiated flag, and all other bits are zero.
- R6: Data is returned only when `rden_mubi_i` equals 4'h6 and `fuse_mubi_i` equals 8'h96. Any other value forces every word to zero. This includes the false codes 4'h9 and 8'h69 and any invalid code.
- R7: After a select write of an index of `HW_CTX+1` or more, every word reads as zero.
- R8: A select write returns the word pointer to word 0, even in the middle of a stream.
- R9: An accepted read of the status word wraps the pointer back to word 0.
- R10: The pointer moves only on an accepted read. While `rd_valid_i` is low, the presented word is held.
- R11: After reset, context 0 is selected and the pointer is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Select write strobe |
| sel_idx_i | input | SEL_W | Context index to select |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request ready |
| rd_data_o | output | WORD_W | Current state word |
| rden_mubi_i | input | 4 | Read-enable control, multi-bit encoded |
| fuse_mubi_i | input | 8 | Fuse-derived enable, multi-bit encoded |
| ctr_i | input | (HW_CTX+1)*CTR_W | Reseed counters of all contexts, context 0 in the low bits |
| v_i | input | (HW_CTX+1)*V_W | V blocks of all contexts |
| key_i | input | (HW_CTX+1)*KEY_W | Keys of all contexts |
| compliance_i | input | HW_CTX+1 | Compliance flag per context |
| inst_i | input | HW_CTX+1 | Instantiated flag per context |

## Verification
The bench walks through these corner cases:

- **Full streams.** It reads whole streams from every context, including the software context. A design that emits a field most significant word first, or reorders the fields, returns a tagged word from the wrong place.
- **Gating.** It drives false and invalid codes on each enable separately. A design that gates on only one bit or one enable leaks nonzero words.
- **Bad index.** It selects an out-of-range index. A design that does not clamp the index returns a neighbour's state.
- **Wrap, reselect and idle.** It reads past the status word, reselects in mid-stream, and leaves the channel idle for several cycles. A design that fails to wrap, fails to restart on reselect, or advances without a handshake shows up as a skipped or repeated word.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam logic [3:0] RDEN_TRUE = 4'h6;
  localparam logic [7:0] FUSE_TRUE = 8'h96;
endpackage

// File: rtl/srw_select.sv
module srw_select #(
  parameter int SEL_W = 4,
  parameter int NCTX  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_idx_i,
  output logic [IDX_W-1:0] ctx_q,
  output logic             sel_ok_q
);
  logic in_range;
  assign in_range = (sel_idx_i < SEL_W'(NCTX));

  // Out-of-range indices are clamped to context 0 and flagged invalid.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q    <= '0;
      sel_ok_q <= 1'b1;
    end else if (sel_we_i) begin
      ctx_q    <= in_range ? IDX_W'(sel_idx_i) : '0;
      sel_ok_q <= in_range;
    end
  end
endmodule

// File: rtl/srw_sequencer.sv
module srw_sequencer #(
  parameter int PTR_W  = 4,
  parameter int NWORDS = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             accept_i,
  output logic [PTR_W-1:0] ptr_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (restart_i) begin
      ptr_q <= '0;
    end else if (accept_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/srw_word_mux.sv
module srw_word_mux #(
  parameter int WORD_W = 32,
  parameter int CTR_W  = 32,
  parameter int V_W    = 128,
  parameter int KEY_W  = 256,
  parameter int NCTX   = 4,
  parameter int IDX_W  = 2,
  parameter int PTR_W  = 4
) (
  input  logic [IDX_W-1:0]      ctx_i,
  input  logic [PTR_W-1:0]      ptr_i,
  input  logic [NCTX*CTR_W-1:0] ctr_i,
  input  logic [NCTX*V_W-1:0]   v_i,
  input  logic [NCTX*KEY_W-1:0] key_i,
  input  logic [NCTX-1:0]       compliance_i,
  input  logic [NCTX-1:0]       inst_i,
  output logic [WORD_W-1:0]     word_o
);
  localparam int CW     = CTR_W / WORD_W;
  localparam int VW     = V_W / WORD_W;
  localparam int KW     = KEY_W / WORD_W;
  localparam int NWORDS = CW + VW + KW + 1;

  logic [CTR_W-1:0]  ctr_sel;
  logic [V_W-1:0]    v_sel;
  logic [KEY_W-1:0]  key_sel;
  logic [WORD_W-1:0] words [NWORDS];

  assign ctr_sel = ctr_i[ctx_i*CTR_W +: CTR_W];
  assign v_sel   = v_i[ctx_i*V_W +: V_W];
  assign key_sel = key_i[ctx_i*KEY_W +: KEY_W];

  // Word order: counter, V, key, status; each field low word first.
  for (genvar gc = 0; gc < CW; gc++) begin : g_ctr
    assign words[gc] = ctr_sel[gc*WORD_W +: WORD_W];
  end
  for (genvar gv = 0; gv < VW; gv++) begin : g_v
    assign words[CW+gv] = v_sel[gv*WORD_W +: WORD_W];
  end
  for (genvar gk = 0; gk < KW; gk++) begin : g_key
    assign words[CW+VW+gk] = key_sel[gk*WORD_W +: WORD_W];
  end
  assign words[NWORDS-1] = {{(WORD_W-2){1'b0}}, compliance_i[ctx_i], inst_i[ctx_i]};

  assign word_o = words[ptr_i];
endmodule

// File: rtl/state_readout_window.sv
module state_readout_window #(
  parameter int HW_CTX = 3,
  parameter int WORD_W = 32,
  parameter int CTR_W  = 32,
  parameter int V_W    = 128,
  parameter int KEY_W  = 256,
  parameter int SEL_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sel_we_i,
  input  logic [SEL_W-1:0]             sel_idx_i,
  input  logic                         rd_valid_i,
  output logic                         rd_ready_o,
  output logic [WORD_W-1:0]            rd_data_o,
  input  logic [3:0]                   rden_mubi_i,
  input  logic [7:0]                   fuse_mubi_i,
  input  logic [(HW_CTX+1)*CTR_W-1:0]  ctr_i,
  input  logic [(HW_CTX+1)*V_W-1:0]    v_i,
  input  logic [(HW_CTX+1)*KEY_W-1:0]  key_i,
  input  logic [HW_CTX:0]              compliance_i,
  input  logic [HW_CTX:0]              inst_i
);
  import srw_pkg::*;

  localparam int NCTX   = HW_CTX + 1;
  localparam int IDX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int NWORDS = (CTR_W + V_W + KEY_W) / WORD_W + 1;
  localparam int PTR_W  = $clog2(NWORDS);

  logic [IDX_W-1:0]  ctx_q;
  logic              sel_ok_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] raw_word;
  logic              unlocked;
  logic              accept;

  assign rd_ready_o = !sel_we_i;
  assign accept     = rd_valid_i && rd_ready_o;

  srw_select #(.SEL_W(SEL_W), .NCTX(NCTX), .IDX_W(IDX_W)) u_select (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_we_i (sel_we_i),
    .sel_idx_i(sel_idx_i),
    .ctx_q    (ctx_q),
    .sel_ok_q (sel_ok_q)
  );

  srw_sequencer #(.PTR_W(PTR_W), .NWORDS(NWORDS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(sel_we_i),
    .accept_i (accept),
    .ptr_q    (ptr_q)
  );

  srw_word_mux #(
    .WORD_W(WORD_W), .CTR_W(CTR_W), .V_W(V_W), .KEY_W(KEY_W),
    .NCTX(NCTX), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_mux (
    .ctx_i       (ctx_q),
    .ptr_i       (ptr_q),
    .ctr_i       (ctr_i),
    .v_i         (v_i),
    .key_i       (key_i),
    .compliance_i(compliance_i),
    .inst_i      (inst_i),
    .word_o      (raw_word)
  );

  // Both redundant enables must hold their exact true code.
  assign unlocked  = (rden_mubi_i == RDEN_TRUE) && (fuse_mubi_i == FUSE_TRUE) && sel_ok_q;
  assign rd_data_o = unlocked ? raw_word : '0;
endmodule

// File: rtl/state_readout_window_chk.sv
module state_readout_window_chk #(
  parameter int WORD_W    = 32,
  parameter int PTR_W     = 4,
  parameter int LAST_WORD = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_we_i,
  input logic              rd_valid_i,
  input logic              rd_ready_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [3:0]        rden_mubi_i,
  input logic [7:0]        fuse_mubi_i,
  input logic [PTR_W-1:0]  ptr_q,
  input logic              sel_ok_q
);
  logic acc;
  assign acc = rd_valid_i && rd_ready_o;

  AST_LOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rden_mubi_i == 4'h6 && fuse_mubi_i == 8'h96) |-> rd_data_o == '0); // R6
  AST_BADIDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok_q |-> rd_data_o == '0); // R7
  AST_WRITE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |-> !rd_ready_o); // R2
  AST_SEL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> ptr_q == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && !acc) |=> $stable(ptr_q)); // R10
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && acc && ptr_q != PTR_W'(LAST_WORD)) |=> ptr_q == $past(ptr_q) + PTR_W'(1)); // R10
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && acc && ptr_q == PTR_W'(LAST_WORD)) |=> ptr_q == '0); // R9
endmodule

bind state_readout_window state_readout_window_chk #(
  .WORD_W(WORD_W), .PTR_W(PTR_W), .LAST_WORD(NWORDS - 1)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_we_i   (sel_we_i),
  .rd_valid_i (rd_valid_i),
  .rd_ready_o (rd_ready_o),
  .rd_data_o  (rd_data_o),
  .rden_mubi_i(rden_mubi_i),
  .fuse_mubi_i(fuse_mubi_i),
  .ptr_q      (ptr_q),
  .sel_ok_q   (sel_ok_q)
);

// File: tb/state_readout_window_tb.sv
`timescale 1ns/1ps
module state_readout_window_tb;
  localparam int HW_CTX = 3;
  localparam int NCTX   = HW_CTX + 1;
  localparam int NW     = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [3:0]  sel_idx = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic [3:0]  rden = 4'h6;
  logic [7:0]  fuse = 8'h96;
  logic [NCTX*32-1:0]  ctr;
  logic [NCTX*128-1:0] vv;
  logic [NCTX*256-1:0] key;
  logic [NCTX-1:0]     comp;
  logic [NCTX-1:0]     inst;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  state_readout_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_idx_i(sel_idx),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_data_o(rd_data),
    .rden_mubi_i(rden), .fuse_mubi_i(fuse), .ctr_i(ctr), .v_i(vv), .key_i(key),
    .compliance_i(comp), .inst_i(inst)
  );

  // Tagged state: top nibble = field, bits 23:16 = context, low bits = word number.
  function automatic logic [31:0] exp_word(int c, int w, logic [3:0] re, logic [7:0] fe);
    if (c >= NCTX || re != 4'h6 || fe != 8'h96) return 32'h0;
    if (w == 0) return 32'h1000_0000 | (c << 16);
    if (w <= 4) return 32'h2000_0000 | (c << 16) | (w - 1);
    if (w <= 12) return 32'h3000_0000 | (c << 16) | (w - 5);
    return {30'b0, (c == 1 || c == 3) ? 1'b1 : 1'b0, (c >= 2) ? 1'b1 : 1'b0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sel_write(logic [3:0] idx);
    @(negedge clk);
    sel_we = 1'b1; sel_idx = idx;
    @(posedge clk); #1;
    sel_we = 1'b0;
  endtask

  task automatic read_check(string req, logic [31:0] exp);
    @(negedge clk);
    rd_valid = 1'b1;
    #1;
    chk(req, rd_data, exp);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  // {ctx[3:0], nreads[4:0], rden[3:0], fuse[7:0]}
  localparam logic [20:0] VEC [9] = '{
    {4'd3, 5'd14, 4'h6, 8'h96},   // R1 R3 R4 R5 software context
    {4'd0, 5'd14, 4'h6, 8'h96},   // R3 R4
    {4'd1, 5'd17, 4'h6, 8'h96},   // R9 wrap
    {4'd2, 5'd14, 4'h6, 8'h96},   // R5
    {4'd5, 5'd3,  4'h6, 8'h96},   // R7 out of range
    {4'd2, 5'd4,  4'h9, 8'h96},   // R6 rden false
    {4'd1, 5'd4,  4'h6, 8'h69},   // R6 fuse false
    {4'd3, 5'd4,  4'hA, 8'h96},   // R6 rden invalid
    {4'd0, 5'd3,  4'h6, 8'hA5}    // R6 fuse invalid
  };

  initial begin
    for (int c = 0; c < NCTX; c++) begin
      ctr[c*32 +: 32] = 32'h1000_0000 | (c << 16);
      for (int k = 0; k < 4; k++) vv[c*128 + k*32 +: 32] = 32'h2000_0000 | (c << 16) | k;
      for (int k = 0; k < 8; k++) key[c*256 + k*32 +: 32] = 32'h3000_0000 | (c << 16) | k;
      comp[c] = (c == 1 || c == 3);
      inst[c] = (c >= 2);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state presents context 0, word 0
    @(negedge clk);
    chk("R11 reset word", rd_data, exp_word(0, 0, 4'h6, 8'h96));
    chk("R11 reset ready", {31'b0, rd_ready}, 32'h1);

    for (int i = 0; i < 9; i++) begin
      logic [3:0] cx = VEC[i][20:17];
      int nr = int'(VEC[i][16:12]);
      rden = VEC[i][11:8];
      fuse = VEC[i][7:0];
      sel_write(cx);
      for (int r = 0; r < nr; r++)
        read_check($sformatf("R1/R3/R4/R6/R7/R9 vec%0d word%0d", i, r),
                   exp_word(int'(cx), r % NW, rden, fuse));
    end
    rden = 4'h6; fuse = 8'h96;

    // R8 + R2: reselect mid-stream while a request is pending
    sel_write(4'd2);
    for (int r = 0; r < 3; r++) read_check("R8 pre", exp_word(2, r, rden, fuse));
    @(negedge clk);
    sel_we = 1'b1; sel_idx = 4'd3; rd_valid = 1'b1;
    #1 chk("R2 ready low on select", {31'b0, rd_ready}, 32'h0);
    @(posedge clk); #1;
    sel_we = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    chk("R2 first word next cycle", rd_data, exp_word(3, 0, rden, fuse));
    read_check("R8 restart word0", exp_word(3, 0, rden, fuse));

    // R10: idle cycles hold the pointer
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 idle hold", rd_data, exp_word(3, 1, rden, fuse));
    read_check("R10 next after idle", exp_word(3, 1, rden, fuse));
    read_check("R10 advance", exp_word(3, 2, rden, fuse));

    // R6: gating change mid-stream does not move the pointer
    rden = 4'h9;
    @(negedge clk);
    chk("R6 gated", rd_data, 32'h0);
    rden = 4'h6;
    read_check("R6 ungated resume", exp_word(3, 3, rden, fuse));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule